// File: doc/BRIEF.md
# DMA Request Arbiter with Acknowledge and Terminal Count

This block sits between four external DMA requesters and a shared transfer datapath. On every rising edge of the bus clock it looks at the four request lines. It ignores channels that are switched off or have no transfers left. Among the rest it grants one channel by fixed priority. Channel 0 wins over 1, 1 over 2, and 2 over 3. The grant starts one beat. The block drives the granted channel's acknowledge line for the cycle after the edge, hands a beat to the datapath, and counts down that channel's remaining transfers. When the last transfer is granted, the channel's terminal-count line pulses alongside that final acknowledge. An option folds every terminal-count event onto the channel 0 line.

Requests are level signals and nothing remembers them. A requester holds its line until it sees its acknowledge. It drops the line in the acknowledge cycle when it wants no further beats. Software loads each channel's count with a load strobe. A loaded count of zero leaves the channel idle. Arbitration is redone on every edge, so a higher-priority request takes over between two beats of a lower-priority channel.

The beat output is a valid/ready stream that carries the granted channel index. A beat stays on the output, unchanged, until the datapath takes it with ready high. While a beat waits with ready low, the block grants nothing, acknowledges nothing and leaves every count alone. A new beat can be granted on the same edge where the waiting beat is taken.

Top module: `dma_req_arbiter`

## Requirements
- R1: A synchronous active-high reset clears every acknowledge, every terminal-count output, the beat valid flag and every remaining count. After reset, no channel is granted until its count is loaded.
- R2: When several eligible channels request on the same edge, the grant goes to the lowest-numbered one (channel 0 highest, channel 3 lowest). This is re-decided on every edge, so a higher-priority channel preempts between beats.
- R3: A grant made at a clock edge shows in the cycle after that edge. That cycle has the granted channel's acknowledge bit (bit c of the acknowledge vector for channel c) high, the beat valid flag high and the beat channel index equal to c.
- R4: Each grant takes one from the channel's remaining count. A channel loaded with N gives exactly N acknowledge cycles, however long its request stays high.
- R5: With the merge option off, the terminal-count bit of a channel is high only in the acknowledge cycle of its final beat. It lasts exactly one cycle.
- R6: With the merge option on, bit 0 of the terminal-count output is the OR of every channel's terminal-count event, and bits 1 to 3 stay low.
- R7: A channel whose enable input is low, or whose remaining count is zero, is never granted, even while its request is high.
- R8: While the beat valid flag is high and ready is low, no grant happens: no acknowledge, and the beat index and valid flag hold.
- R9: A channel whose load strobe is high on an edge is not granted at that edge. The loaded value replaces its remaining count.
- R10: A request that drops before being granted leaves no trace, and no grant follows from it later.
- R11: At most one acknowledge bit is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock; every input is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NCH | Level request per channel |
| chan_en_i | input | NCH | Per-channel enable |
| load_i | input | NCH | Per-channel count load strobe |
| load_cnt_i | input | NCH*CW | Count values, channel c in bits c*CW +: CW |
| tc_merge_i | input | 1 | Fold all terminal-count events onto bit 0 |
| ack_o | output | NCH | Per-channel acknowledge, one cycle per beat |
| tc_o | output | NCH | Per-channel terminal-count pulse |
| beat_valid_o | output | 1 | A granted beat is waiting for the datapath |
| beat_ready_i | input | 1 | Datapath takes the beat |
| beat_chan_o | output | IW | Channel index of the waiting beat |

## Verification
Every cycle, the assertions check these properties:
- acknowledges are one-hot;
- every acknowledge matches a valid beat of the same channel and a request present at the previous edge;
- a stalled beat holds with no acknowledge;
- terminal-count pulses occur only together with an acknowledge;
- merged terminal counts use bit 0 alone;
- reset clears the outputs.

Some properties need the bench's scenarios: the priority choice over every combination of requests and enables, the exact count of beats and the position of the terminal-count pulse for several loaded counts, preemption between beats, and the load-edge exclusion. So does the fact that a withdrawn request is not remembered.

// File: rtl/dmarb_pkg.sv
package dmarb_pkg;
  localparam int unsigned DEF_NCH = 4;
  localparam int unsigned DEF_CW  = 8;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/dmarb_chan.sv
module dmarb_chan #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          en,
  input  logic          take,
  output logic          elig,
  output logic          last
);
  logic [CW-1:0] remain_q;
  localparam logic [CW-1:0] ONE = CW'(1);

  // a channel being reloaded sits out this edge
  assign elig = en && (remain_q != '0) && !load;
  assign last = (remain_q == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= '0;
    end else if (load) begin
      remain_q <= load_val;
    end else if (take) begin
      remain_q <= remain_q - ONE;
    end
  end
endmodule

// File: rtl/dmarb_prio.sv
module dmarb_prio #(
  parameter int unsigned NCH = 4,
  parameter int unsigned IW  = 2
) (
  input  logic [NCH-1:0] cand,
  output logic [NCH-1:0] grant,
  output logic [IW-1:0]  idx,
  output logic           any
);
  logic [NCH:0] seen;
  assign seen[0] = 1'b0;

  for (genvar c = 0; c < NCH; c++) begin : g_chain
    assign seen[c+1] = seen[c] | cand[c];
    assign grant[c]  = cand[c] & ~seen[c];
  end

  assign any = seen[NCH];

  always_comb begin
    idx = '0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (cand[c]) idx = IW'(c);
    end
  end
endmodule

// File: rtl/dmarb_tcmux.sv
module dmarb_tcmux #(
  parameter int unsigned NCH = 4
) (
  input  logic           merge,
  input  logic [NCH-1:0] tc_ev,
  output logic [NCH-1:0] tc_out
);
  always_comb begin
    if (merge) begin
      tc_out    = '0;
      tc_out[0] = |tc_ev;
    end else begin
      tc_out = tc_ev;
    end
  end
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
  import dmarb_pkg::*;
#(
  parameter int unsigned NCH = DEF_NCH,
  parameter int unsigned CW  = DEF_CW,
  parameter int unsigned IW  = idx_width(NCH)
) (
  input  logic              bus_clk,
  input  logic              rst,
  input  logic [NCH-1:0]    req_i,
  input  logic [NCH-1:0]    chan_en_i,
  input  logic [NCH-1:0]    load_i,
  input  logic [NCH*CW-1:0] load_cnt_i,
  input  logic              tc_merge_i,
  output logic [NCH-1:0]    ack_o,
  output logic [NCH-1:0]    tc_o,
  output logic              beat_valid_o,
  input  logic              beat_ready_i,
  output logic [IW-1:0]     beat_chan_o
);
  logic [NCH-1:0] elig, last, cand, grant, take, tc_ev, tc_next;
  logic [IW-1:0]  pick_idx;
  logic           pick_any, slot_free, issue;

  logic [NCH-1:0] ack_q, tc_q;
  logic           bv_q;
  logic [IW-1:0]  bch_q;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    dmarb_chan #(.CW(CW)) u_chan (
      .clk      (bus_clk),
      .rst      (rst),
      .load     (load_i[c]),
      .load_val (load_cnt_i[c*CW +: CW]),
      .en       (chan_en_i[c]),
      .take     (take[c]),
      .elig     (elig[c]),
      .last     (last[c])
    );
  end

  assign cand = req_i & elig;

  dmarb_prio #(.NCH(NCH), .IW(IW)) u_prio (
    .cand  (cand),
    .grant (grant),
    .idx   (pick_idx),
    .any   (pick_any)
  );

  // output slot is free when empty or being drained this edge
  assign slot_free = !bv_q || beat_ready_i;
  assign issue     = slot_free && pick_any;
  assign take      = issue ? grant : '0;
  assign tc_ev     = take & last;

  dmarb_tcmux #(.NCH(NCH)) u_tcmux (
    .merge  (tc_merge_i),
    .tc_ev  (tc_ev),
    .tc_out (tc_next)
  );

  always_ff @(posedge bus_clk) begin
    if (rst) begin
      ack_q <= '0;
      tc_q  <= '0;
      bv_q  <= 1'b0;
      bch_q <= '0;
    end else begin
      ack_q <= take;
      tc_q  <= tc_next;
      if (slot_free) begin
        bv_q <= pick_any;
        if (pick_any) bch_q <= pick_idx;
      end
    end
  end

  assign ack_o        = ack_q;
  assign tc_o         = tc_q;
  assign beat_valid_o = bv_q;
  assign beat_chan_o  = bch_q;
endmodule

// File: rtl/dmarb_checker.sv
module dmarb_checker #(
  parameter int unsigned NCH = 4,
  parameter int unsigned IW  = 2
) (
  input logic           bus_clk,
  input logic           rst,
  input logic [NCH-1:0] req_i,
  input logic           tc_merge_i,
  input logic [NCH-1:0] ack_o,
  input logic [NCH-1:0] tc_o,
  input logic           beat_valid_o,
  input logic           beat_ready_i,
  input logic [IW-1:0]  beat_chan_o
);
  p_reset_clear_r1: assert property (@(posedge bus_clk)
    rst |=> (ack_o == '0) && (tc_o == '0) && !beat_valid_o);

  p_ack_onehot_r11: assert property (@(posedge bus_clk) disable iff (rst)
    $onehot0(ack_o));

  p_ack_matches_beat_r3: assert property (@(posedge bus_clk) disable iff (rst)
    (|ack_o) |-> (beat_valid_o && ack_o[beat_chan_o]));

  p_ack_needs_req_r3: assert property (@(posedge bus_clk) disable iff (rst)
    (ack_o & ~$past(req_i)) == '0);

  p_stall_hold_r8: assert property (@(posedge bus_clk) disable iff (rst)
    (beat_valid_o && !beat_ready_i) |=>
      (beat_valid_o && $stable(beat_chan_o) && (ack_o == '0)));

  p_tc_with_ack_r5: assert property (@(posedge bus_clk) disable iff (rst)
    (|tc_o) |-> (|ack_o));

  p_merge_bit0_r6: assert property (@(posedge bus_clk) disable iff (rst)
    $past(tc_merge_i) |-> (tc_o[NCH-1:1] == '0));
endmodule

bind dma_req_arbiter dmarb_checker #(.NCH(NCH), .IW(IW)) u_chk (
  .bus_clk      (bus_clk),
  .rst          (rst),
  .req_i        (req_i),
  .tc_merge_i   (tc_merge_i),
  .ack_o        (ack_o),
  .tc_o         (tc_o),
  .beat_valid_o (beat_valid_o),
  .beat_ready_i (beat_ready_i),
  .beat_chan_o  (beat_chan_o)
);

// File: tb/sim_dma_req_arbiter.sv
`timescale 1ns/1ps
module sim_dma_req_arbiter;
  localparam int NCH = 4;
  localparam int CW  = 8;
  localparam int IW  = 2;

  logic              bus_clk = 1'b0;
  logic              rst;
  logic [NCH-1:0]    req_i, chan_en_i, load_i;
  logic [NCH*CW-1:0] load_cnt_i;
  logic              tc_merge_i, beat_ready_i;
  logic [NCH-1:0]    ack_o, tc_o;
  logic              beat_valid_o;
  logic [IW-1:0]     beat_chan_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 bus_clk = ~bus_clk;

  dma_req_arbiter #(.NCH(NCH), .CW(CW)) u0 (
    .bus_clk(bus_clk), .rst(rst), .req_i(req_i), .chan_en_i(chan_en_i),
    .load_i(load_i), .load_cnt_i(load_cnt_i), .tc_merge_i(tc_merge_i),
    .ack_o(ack_o), .tc_o(tc_o), .beat_valid_o(beat_valid_o),
    .beat_ready_i(beat_ready_i), .beat_chan_o(beat_chan_o)
  );

  task automatic step();
    @(negedge bus_clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load_all(input int val);
    req_i  = '0;
    load_i = '1;
    for (int c = 0; c < NCH; c++) load_cnt_i[c*CW +: CW] = CW'(val);
    step();
    load_i = '0;
  endtask

  initial begin
    repeat (200000) @(posedge bus_clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; req_i = '0; chan_en_i = '0; load_i = '0; load_cnt_i = '0;
    tc_merge_i = 1'b0; beat_ready_i = 1'b1;
    step(); step();
    check("R1 ack after reset", 32'(ack_o), 0);
    check("R1 tc after reset", 32'(tc_o), 0);
    check("R1 valid after reset", 32'(beat_valid_o), 0);
    rst = 1'b0;
    // counts are zero after reset: nothing granted
    req_i = '1; chan_en_i = '1;
    step();
    check("R1 no grant with cleared counts", 32'(ack_o), 0);
    check("R7 zero count ignored", 32'(beat_valid_o), 0);
    req_i = '0; step();

    // R2/R7 sweep over every enable and request pattern
    for (int en = 0; en < 16; en++) begin
      for (int rq = 0; rq < 16; rq++) begin
        int cand, exp_ack, exp_idx;
        load_all(5);
        cand    = rq & en;
        exp_ack = cand & (-cand);
        exp_idx = (exp_ack == 8) ? 3 : (exp_ack == 4) ? 2 : (exp_ack == 2) ? 1 : 0;
        chan_en_i = NCH'(en);
        req_i     = NCH'(rq);
        step();
        check("R2/R7 sweep ack", 32'(ack_o), 32'(exp_ack));
        check("R3 sweep valid", 32'(beat_valid_o), 32'(exp_ack != 0));
        if (exp_ack != 0) check("R3 sweep index", 32'(beat_chan_o), 32'(exp_idx));
        req_i = '0;
        step();
      end
    end

    // R4/R5 beat count and terminal-count position on channel 2
    chan_en_i = '1;
    for (int n = 1; n <= 6; n++) begin
      load_i = 4'b0100; load_cnt_i = '0; load_cnt_i[2*CW +: CW] = CW'(n);
      step();
      load_i = '0;
      req_i  = 4'b0100;
      for (int i = 1; i <= n + 2; i++) begin
        step();
        check("R4 ack per beat", 32'(ack_o), (i <= n) ? 32'h4 : 32'h0);
        check("R5 tc on final beat", 32'(tc_o), (i == n) ? 32'h4 : 32'h0);
      end
      req_i = '0; step();
    end

    // R6 merge: channel 3 final beat reported on bit 0
    tc_merge_i = 1'b1;
    load_i = 4'b1000; load_cnt_i = '0; load_cnt_i[3*CW +: CW] = CW'(1);
    step();
    load_i = '0; req_i = 4'b1000;
    step();
    check("R6 merged tc", 32'(tc_o), 32'h1);
    check("R6 merged ack", 32'(ack_o), 32'h8);
    req_i = '0; step();
    tc_merge_i = 1'b0;

    // R8 back-pressure
    load_all(3);
    beat_ready_i = 1'b0; req_i = 4'b0010;
    step();
    check("R8 first beat", 32'(ack_o), 32'h2);
    step();
    check("R8 stalled no ack", 32'(ack_o), 0);
    check("R8 stalled valid", 32'(beat_valid_o), 1);
    check("R8 stalled index", 32'(beat_chan_o), 1);
    beat_ready_i = 1'b1;
    step();
    check("R8 resume grant", 32'(ack_o), 32'h2);
    req_i = '0; step();

    // R2 preemption between beats
    load_all(5);
    req_i = 4'b1000; step();
    check("R2 low channel served", 32'(ack_o), 32'h8);
    req_i = 4'b1001; step();
    check("R2 preempt by channel 0", 32'(ack_o), 32'h1);
    check("R2 preempt index", 32'(beat_chan_o), 0);
    req_i = 4'b1000; step();
    check("R2 back to channel 3", 32'(ack_o), 32'h8);
    req_i = '0; step();

    // R9 load edge excludes the channel
    load_i = 4'b0010; load_cnt_i = '0; load_cnt_i[1*CW +: CW] = CW'(4);
    req_i = 4'b0010;
    step();
    check("R9 no grant on load edge", 32'(ack_o), 0);
    load_i = '0;
    step();
    check("R9 grant after load", 32'(ack_o), 32'h2);
    req_i = '0; step();

    // R10 withdrawn request not remembered
    load_all(5);
    req_i = 4'b0011; step();
    check("R10 channel 0 wins", 32'(ack_o), 32'h1);
    req_i = '0; step();
    check("R10 no late grant", 32'(ack_o), 0);
    check("R10 no late beat", 32'(beat_valid_o), 0);

    // R7 enable low while count non-zero
    chan_en_i = 4'b1011; req_i = 4'b0100; step();
    check("R7 disabled channel ignored", 32'(ack_o), 0);
    req_i = '0; step();

    // R1 reset clears counts
    rst = 1'b1; step(); rst = 1'b0;
    chan_en_i = '1; req_i = '1; step();
    check("R1 counts cleared by reset", 32'(ack_o), 0);
    req_i = '0; step();

    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule